// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block acts as a bus master toward a 16-bit parallel NOR flash that uses the unlock-cycle command set. A host hands it one request at a time: either erase the sector that starts at a given byte address, or program one data word at a given byte address. The block issues the write cycles that make up the command, polls the target by reading it back, and returns the device to read-array mode. It then reports one of four outcomes on a one-cycle completion pulse.

Requests enter on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The host must hold `req_valid`, `req_prog`, `req_addr` and `req_data` steady until that edge. While an operation is in flight, `req_ready` stays low, so a waiting request is back-pressured rather than lost. It is accepted on the first edge after the completion pulse. The completion side has no back-pressure: `done` is a single-cycle pulse and the host must catch it.

On the flash side, every bus cycle holds its strobe for `BUS_CLKS` clocks, and the block waits at least one idle clock before the next cycle. Read data is sampled on the last clock of a read strobe. Status codes are 0 for success, 1 for timeout, 2 for not-erased and 3 for program error.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every erase, and every program that passes its pre-check, begins with two unlock writes. The first writes 0x00AA to byte address 0xAAA (word offset 0x555). The second writes 0x0055 to byte address 0x554 (word offset 0x2AA).
- R2: An erase issues these writes in this order: unlock pair, 0x0080 to 0xAAA, unlock pair, then 0x0030 to the sector address.
- R3: A program issues these writes in this order: unlock pair, 0x00A0 to 0xAAA, then the data word to the target address.
- R4: A program first reads the target once. If (read AND data) is not equal to data, the block reports status 2 with no write cycle at all.
- R5: After the erase confirm write, the block reads the sector address repeatedly. It stops at the first read whose bit 7 is 1.
- R6: After the program data write, the block reads the target repeatedly. It stops at the first read whose bit 7 equals bit 7 of the data.
- R7: If polling has run for at least `TMO_CLKS` clocks after the final command write without completing, the block stops polling. It writes 0x00F0 to 0xAAA and reports status 1, with no verify read.
- R8: Every operation that issued command writes ends with exactly one write of 0x00F0 to 0xAAA before `done`.
- R9: After a program that completed polling returns to read mode, the block reads the target once more. It reports status 0 if the value equals the data and status 3 otherwise.
- R10: `req_ready` is high only when idle. No request is accepted while an operation is in flight. `done` lasts exactly one cycle and carries `done_status`.
- R11: `fl_we` and `fl_re` are never high together. Each strobe lasts `BUS_CLKS` clocks with address and write data stable. Consecutive strobes are separated by at least one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_prog | input | 1 | 1 = program word, 0 = erase sector |
| req_addr | input | AW | Byte address of sector or target word |
| req_data | input | 16 | Word to program (ignored for erase) |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 timeout, 2 not-erased, 3 program error |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_rdata | input | 16 | Flash read data |

## Verification
Erases are tried with a flash that reports completion on the first poll and with one that needs several polls. This shows whether the poll loop stops on the right bit-7 value rather than after a fixed count. Programs are tried on an erased word, on a partly programmed but compatible word, and on an incompatible word. These cases separate the AND-based pre-check from a plain equality test. Programs are also tried with data whose bit 7 is 1 and 0, which exposes a completion test that ignores the data bit. Separate cases cover a flash that never completes, which checks the timeout window and that no verify read follows, and a corrupted verify readback. A second request held valid during a busy operation checks the back-pressure.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_TIMEOUT    = 2'd1,
    ST_NOT_ERASED = 2'd2,
    ST_PROG_ERR   = 2'd3
  } nor_status_e;

  typedef enum logic [1:0] {
    AK_UNLOCK_A = 2'd0,
    AK_UNLOCK_B = 2'd1,
    AK_TARGET   = 2'd2
  } addr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRECHK, S_CMDS, S_POLL, S_RDARR, S_VERIFY, S_DONE
  } seq_state_e;

  localparam logic [15:0] CMD_UNLOCK_A = 16'h00AA;
  localparam logic [15:0] CMD_UNLOCK_B = 16'h0055;
  localparam logic [15:0] CMD_ERASE    = 16'h0080;
  localparam logic [15:0] CMD_SECTOR   = 16'h0030;
  localparam logic [15:0] CMD_WRITE    = 16'h00A0;
  localparam logic [15:0] CMD_READMODE = 16'h00F0;

endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_seq_pkg::*;
(
  input  logic       is_prog,
  input  logic [2:0] step,
  output addr_kind_e kind,
  output logic [15:0] cmd,
  output logic       use_data,
  output logic       last
);
  always_comb begin
    kind     = AK_UNLOCK_A;
    cmd      = CMD_UNLOCK_A;
    use_data = 1'b0;
    last     = 1'b0;
    if (is_prog) begin
      case (step)
        3'd0: begin kind = AK_UNLOCK_A; cmd = CMD_UNLOCK_A; end
        3'd1: begin kind = AK_UNLOCK_B; cmd = CMD_UNLOCK_B; end
        3'd2: begin kind = AK_UNLOCK_A; cmd = CMD_WRITE;    end
        default: begin kind = AK_TARGET; use_data = 1'b1; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0, 3'd3: begin kind = AK_UNLOCK_A; cmd = CMD_UNLOCK_A; end
        3'd1, 3'd4: begin kind = AK_UNLOCK_B; cmd = CMD_UNLOCK_B; end
        3'd2:       begin kind = AK_UNLOCK_A; cmd = CMD_ERASE;    end
        default:    begin kind = AK_TARGET; cmd = CMD_SECTOR; last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/nor_bus_cyc.sv
module nor_bus_cyc #(
  parameter int AW       = 21,
  parameter int DW       = 16,
  parameter int BUS_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          fin,
  output logic [DW-1:0] rd_word,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata
);
  localparam int CW = (BUS_CLKS > 1) ? $clog2(BUS_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BUS_CLKS - 1);

  logic          active, is_wr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_wr    <= 1'b0;
      cnt      <= '0;
      fin      <= 1'b0;
      rd_word  <= '0;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else begin
      fin <= 1'b0;
      if (active) begin
        if (cnt == CNT_LAST) begin
          active <= 1'b0;
          fin    <= 1'b1;
          if (!is_wr) rd_word <= fl_rdata;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (go) begin
        active   <= 1'b1;
        is_wr    <= go_wr;
        cnt      <= '0;
        fl_addr  <= go_addr;
        fl_wdata <= go_wr ? go_data : '0;
      end
    end
  end

  assign fl_we = active & is_wr;
  assign fl_re = active & ~is_wr;

  p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  p_stable_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) && cnt != '0 |-> $stable(fl_addr) && $stable(fl_wdata));
  p_idle_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !(fl_we || fl_re));
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TMO_CLKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int TW = $clog2(TMO_CLKS + 1) + 1;
  localparam logic [TW-1:0] LIMIT = TW'(TMO_CLKS);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (cnt < LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= LIMIT);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 21,
  parameter int BUS_CLKS = 2,
  parameter int TMO_CLKS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_prog,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_data,
  output logic          done,
  output logic [1:0]    done_status,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [15:0]   fl_rdata
);
  localparam logic [AW-1:0] ADDR_UA = AW'(32'h0000_0AAA);
  localparam logic [AW-1:0] ADDR_UB = AW'(32'h0000_0554);

  seq_state_e  state;
  nor_status_e status_q;
  logic          op_prog, launch;
  logic [AW-1:0] tgt;
  logic [15:0]   wdat;
  logic [2:0]    step;

  logic          go, go_wr, fin, expired, poll_hit;
  logic [AW-1:0] go_addr;
  logic [15:0]   go_data, rd_word;

  addr_kind_e  rom_kind;
  logic [15:0] rom_cmd;
  logic        rom_use_data, rom_last;

  nor_cmd_rom u_rom (
    .is_prog (op_prog), .step (step), .kind (rom_kind),
    .cmd (rom_cmd), .use_data (rom_use_data), .last (rom_last)
  );

  nor_bus_cyc #(.AW(AW), .DW(16), .BUS_CLKS(BUS_CLKS)) u_bus (
    .clk, .rst_n, .go, .go_wr, .go_addr, .go_data, .fin, .rd_word,
    .fl_addr, .fl_wdata, .fl_we, .fl_re, .fl_rdata
  );

  nor_poll_timer #(.TMO_CLKS(TMO_CLKS)) u_tmr (
    .clk, .rst_n, .clr (state != S_POLL), .expired
  );

  always_comb begin
    go      = launch;
    go_wr   = 1'b0;
    go_addr = tgt;
    go_data = '0;
    case (state)
      S_CMDS: begin
        go_wr   = 1'b1;
        go_data = rom_use_data ? wdat : rom_cmd;
        case (rom_kind)
          AK_UNLOCK_A: go_addr = ADDR_UA;
          AK_UNLOCK_B: go_addr = ADDR_UB;
          default:     go_addr = tgt;
        endcase
      end
      S_RDARR: begin
        go_wr   = 1'b1;
        go_addr = ADDR_UA;
        go_data = CMD_READMODE;
      end
      default: ;
    endcase
  end

  assign poll_hit = op_prog ? (rd_word[7] == wdat[7]) : rd_word[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      status_q <= ST_OK;
      op_prog  <= 1'b0;
      launch   <= 1'b0;
      tgt      <= '0;
      wdat     <= '0;
      step     <= '0;
    end else begin
      launch <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_prog  <= req_prog;
          tgt      <= req_addr;
          wdat     <= req_prog ? req_data : 16'h0;
          step     <= '0;
          status_q <= ST_OK;
          launch   <= 1'b1;
          state    <= req_prog ? S_PRECHK : S_CMDS;
        end
        S_PRECHK: if (fin) begin
          if ((rd_word & wdat) != wdat) begin
            status_q <= ST_NOT_ERASED;
            state    <= S_DONE;
          end else begin
            launch <= 1'b1;
            state  <= S_CMDS;
          end
        end
        S_CMDS: if (fin) begin
          launch <= 1'b1;
          if (rom_last) state <= S_POLL;
          else          step  <= step + 1'b1;
        end
        S_POLL: if (fin) begin
          launch <= 1'b1;
          if (poll_hit) begin
            status_q <= ST_OK;
            state    <= S_RDARR;
          end else if (expired) begin
            status_q <= ST_TIMEOUT;
            state    <= S_RDARR;
          end
        end
        S_RDARR: if (fin) begin
          if (op_prog && status_q == ST_OK) begin
            launch <= 1'b1;
            state  <= S_VERIFY;
          end else begin
            state <= S_DONE;
          end
        end
        S_VERIFY: if (fin) begin
          status_q <= (rd_word == wdat) ? ST_OK : ST_PROG_ERR;
          state    <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign done        = (state == S_DONE);
  assign done_status = status_q;

  // Observation of the flash bus over one operation, used by the checks below.
  logic wr_seen, last_wr_readmode;
  always_ff @(posedge clk) begin
    if (!rst_n || state == S_IDLE) begin
      wr_seen          <= 1'b0;
      last_wr_readmode <= 1'b0;
    end else if (fl_we) begin
      wr_seen          <= 1'b1;
      last_wr_readmode <= (fl_addr == ADDR_UA) && (fl_wdata == CMD_READMODE);
    end
  end

  p_noterased_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_status == ST_NOT_ERASED |-> !wr_seen);
  p_ends_in_readmode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_status != ST_NOT_ERASED |-> last_wr_readmode);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> !req_ready);
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int BUS_CLKS = 2;
  localparam int TMO_CLKS = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_prog = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_ready, done, fl_we, fl_re;
  logic [1:0] done_status;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] rd_reply = 16'hFFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.AW(AW), .BUS_CLKS(BUS_CLKS), .TMO_CLKS(TMO_CLKS)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_prog, .req_addr, .req_data,
    .done, .done_status, .fl_addr, .fl_wdata, .fl_we, .fl_re, .fl_rdata (rd_reply)
  );

  typedef struct {
    bit we; int addr; int data; bit arm; int k; bit nev; bit prog; int post;
  } op_t;

  op_t exp_q[$];
  int  st_q[$];
  logic [15:0] mem [int];

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0;
  bit busy_m = 0, accept_next = 0, prev_strobe = 0, prev_done = 0, wild = 0;
  bit fb_busy = 0, fb_nev = 0, fb_prog = 0, finished = 0;
  int fb_left = 0, fb_tgt = 0, fb_data = 0, fb_final = 0, arm_cyc = 0;

  function automatic void chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endfunction

  function automatic void push(bit we, int a, int d, bit arm = 0, int k = 0,
                               bit nev = 0, bit prog = 0, int post = 0);
    op_t o;
    o.we = we; o.addr = a; o.data = d; o.arm = arm; o.k = k;
    o.nev = nev; o.prog = prog; o.post = post;
    exp_q.push_back(o);
  endfunction

  // R1 unlock pair; R2 erase order; R5 polls until bit 7 set; R8 read-mode exit
  function automatic void exp_erase(int sect, int k, bit nev);
    push(1, 'hAAA, 'hAA); push(1, 'h554, 'h55); push(1, 'hAAA, 'h80);
    push(1, 'hAAA, 'hAA); push(1, 'h554, 'h55);
    push(1, sect, 'h30, 1, k, nev, 0, 'hFFFF);
    if (!nev) for (int i = 0; i <= k; i++) push(0, sect, 0);
    push(1, 'hAAA, 'hF0);
    st_q.push_back(nev ? 1 : 0);
  endfunction

  // R3 program order; R4 pre-check; R6 bit-7 compare; R9 verify
  function automatic void exp_prog(int a, int d, int old, int k, bit nev, int post);
    push(0, a, 0);
    if ((old & d) != d) begin
      st_q.push_back(2);
      return;
    end
    push(1, 'hAAA, 'hAA); push(1, 'h554, 'h55); push(1, 'hAAA, 'hA0);
    push(1, a, d, 1, k, nev, 1, post);
    if (!nev) for (int i = 0; i <= k; i++) push(0, a, 0);
    push(1, 'hAAA, 'hF0);
    if (nev) st_q.push_back(1);
    else begin
      push(0, a, 0);
      st_q.push_back(post == d ? 0 : 3);
    end
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      if (accept_next) busy_m = 1;
      chk(req_ready == !busy_m, "R10 ready", req_ready, !busy_m);
      chk(!(fl_we && fl_re), "R11 dual strobe", {fl_we, fl_re}, 0);
      chk(!(done && prev_done), "R10 done width", done, 0);
      if ((fl_we || fl_re) && !prev_strobe) begin
        int a;
        a = int'(fl_addr);
        if (fl_re) begin
          if (fb_busy && a == fb_tgt) begin
            if (fb_nev || fb_left > 0) begin
              if (!fb_nev) fb_left--;
              rd_reply = fb_prog ? 16'(fb_data ^ 'h80) : 16'h0000;
            end else begin
              fb_busy = 0;
              mem[a] = 16'(fb_final);
              rd_reply = 16'(fb_final);
            end
          end else rd_reply = mem.exists(a) ? mem[a] : 16'hFFFF;
        end
        if (wild && fl_re && a == fb_tgt) begin
          chk(1, "R7 poll", a, fb_tgt);
        end else if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected bus cycle", a, 0);
        end else begin
          op_t o;
          o = exp_q.pop_front();
          chk(fl_we == o.we, "R11 cycle kind", fl_we, o.we);
          chk(a == o.addr, "R1-addr R2 R3 R5 R6 sequence address", a, o.addr);
          if (o.we) chk(int'(fl_wdata) == o.data, "R2 R3 R8 write data", fl_wdata, o.data);
          if (o.we && o.data == 'hF0 && o.addr == 'hAAA && wild) begin
            wild = 0;
            chk(cyc - arm_cyc >= TMO_CLKS + BUS_CLKS + 1 &&
                cyc - arm_cyc <= TMO_CLKS + 3*BUS_CLKS + 8,
                "R7 timeout window", cyc - arm_cyc, TMO_CLKS);
          end
          if (o.arm) begin
            fb_busy = 1; fb_left = o.k; fb_nev = o.nev; fb_tgt = o.addr;
            fb_data = o.data; fb_prog = o.prog; fb_final = o.post;
            arm_cyc = cyc; wild = o.nev;
          end
        end
      end
      if (done) begin
        int es;
        es = (st_q.size() > 0) ? st_q.pop_front() : -1;
        chk(busy_m, "R10 done while idle", 0, 1);
        chk(int'(done_status) == es, "R4 R7 R9 done_status", done_status, es);
        busy_m = 0;
        done_cnt++;
      end
      prev_strobe = fl_we || fl_re;
      prev_done = done;
      accept_next = req_valid && req_ready;
    end
  end

  task automatic request(bit prog, int a, int d);
    @(posedge clk); #1;
    req_prog = prog; req_addr = AW'(a); req_data = 16'(d); req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_done(int n);
    while (done_cnt < n) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R8 sequence complete", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finished = 1;
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R10 reset ready", req_ready, 1);
    chk(!fl_we && !fl_re && !done, "R11 reset strobes", {fl_we, fl_re, done}, 0);

    exp_erase('h8000, 3, 0);            // R5 several busy polls
    request(0, 'h8000, 0); wait_done(1);
    exp_erase('h40000, 0, 0);           // R5 ready on first poll
    request(0, 'h40000, 0); wait_done(2);

    mem['h100] = 16'hFFFF;              // R3 R6 data bit7 = 0
    exp_prog('h100, 'h1234, 'hFFFF, 2, 0, 'h1234);
    request(1, 'h100, 'h1234); wait_done(3);

    mem['h200] = 16'h00FF;              // R4 incompatible old value
    exp_prog('h200, 'h1200, 'h00FF, 0, 0, 0);
    request(1, 'h200, 'h1200); wait_done(4);

    mem['h300] = 16'hF0F0;              // R4 partly programmed but compatible, R6 bit7 = 1
    exp_prog('h300, 'h30B0, 'hF0F0, 1, 0, 'h30B0);
    request(1, 'h300, 'h30B0); wait_done(5);

    mem['h400] = 16'hFFFF;              // R9 verify mismatch
    exp_prog('h400, 'h5678, 'hFFFF, 1, 0, 'h5670);
    request(1, 'h400, 'h5678); wait_done(6);

    exp_erase('h80000, 0, 1);           // R7 erase never completes
    request(0, 'h80000, 0); wait_done(7);

    mem['h500] = 16'hFFFF;              // R7 program timeout, no verify read
    exp_prog('h500, 'h00AA, 'hFFFF, 0, 1, 0);
    request(1, 'h500, 'h00AA); wait_done(8);

    // R10 second request held valid while the first is in flight
    exp_erase('hC0000, 2, 0);
    mem['h600] = 16'hFFFF;
    exp_prog('h600, 'h0F0F, 'hFFFF, 1, 0, 'h0F0F);
    request(0, 'hC0000, 0);
    @(posedge clk); #1;
    req_prog = 1; req_addr = AW'('h600); req_data = 16'h0F0F; req_valid = 1;
    while (done_cnt < 1 + 8) @(posedge clk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    wait_done(10);

    finished = 1;
    summary();
  end
endmodule